// File: doc/BRIEF.md
# Decimating Entropy Word Collector

This block gathers a one-bit raw entropy stream into a 32-bit capture word. A host enables the block, programs a clock divider ratio while the block is still idle, selects a decimation rate and moves the block into its capture state. The block then samples the entropy input on a divided sampling enable. It keeps only the last sample of each decimation group and shifts the kept bits into a word, first bit in the most significant position.

When the word is full the block raises a ready interrupt. It then stops collecting until the host pulses the read strobe. The read strobe clears the interrupt, and collection of the next word begins on the following cycle. Returning the block to its idle state clears the partial word, the bit count and the interrupt at once. The divider setting is locked while the block is capturing or disabled, and its current value can be read back.

Top module: `rng_capture`

## Requirements
- R1: With decimation code 0 and divider 0, every system clock contributes a bit. After capture starts, the ready interrupt is low for the first 32 cycles and high from cycle 32 (counting from 0).
- R2: With decimation code 3 and divider 0, one bit is kept every fourth sampling enable. The interrupt is low for the first 128 cycles of capture and high from cycle 128.
- R3: Divider value r gives one sampling enable every r+1 system clocks. The first enable comes on capture cycle r, so a word takes 32*(r+1)*(d+1) cycles, where d is the decimation code.
- R4: Decimation code d keeps the last bit of each group of d+1 sampling enables. The entropy value present during capture cycle m*(r+1)*(d+1)-1 is the m-th kept bit, for m from 1 to 32.
- R5: Kept bits enter MSB-first. The first kept bit ends in bit 31 of `cap_word` and the 32nd kept bit in bit 0.
- R6: The interrupt rises only on the cycle after the 32nd kept bit. While it is high and no read occurs, it stays high and `cap_word` does not change, whatever the entropy input does.
- R7: A read strobe while the interrupt is high clears it on the next cycle. With divider 0, collection of the next word restarts from that cycle with the same timing as R1 to R4.
- R8: A write on the divider port takes effect only while `enable` is high and the block is in the idle state. Writes while capturing or while disabled leave `div_value` unchanged.
- R9: Within one cycle of the state register reaching idle, `cap_word` reads 0 and the interrupt is low. The state register reaches idle when `run_req` is dropped or `enable` is dropped.
- R10: After reset, `cap_word` is 0, the interrupt is low, `div_value` is 0 and the block is idle.
- R11: A read strobe while the interrupt is low has no effect on the timing or content of the word being collected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low forces the idle state |
| run_req | input | 1 | Requested state: 0 idle, 1 capture |
| div_wr | input | 1 | Divider write strobe |
| div_wdata | input | DIV_W | Divider ratio to write |
| dec_code | input | DEC_W | Decimation code d (keep 1 of d+1) |
| noise_in | input | 1 | Raw entropy bit |
| rd_stb | input | 1 | Host read strobe for the capture word |
| cap_word | output | WORD_W | Capture word |
| rdy_irq | output | 1 | Word-ready interrupt |
| div_value | output | DIV_W | Current divider ratio |

## Verification
The hardest state to reach is a read or an entropy change during the stalled interval after the interrupt rises. Reaching it needs the exact cycle count of a full word, and that count depends on both the divider and the decimation code. The bench computes the word length from the programmed values, drives fresh entropy through the stall and only then reads. It also slips a read strobe into the middle of collection at random offsets, and it restarts a second word straight off the read edge, so that stall, read and restart all fall on known cycles.

// File: rtl/rng_pkg.sv
package rng_pkg;

  typedef enum logic {
    ST_OFF     = 1'b0,
    ST_CAPTURE = 1'b1
  } rng_state_e;

endpackage

// File: rtl/rng_clkdiv.sv
module rng_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             idle,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  output logic [DIV_W-1:0] div_q,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic             wr_ok;

  function automatic logic [DIV_W-1:0] next_phase(input logic [DIV_W-1:0] c,
                                                  input logic [DIV_W-1:0] lim);
    return (c == lim) ? '0 : c + DIV_W'(1);
  endfunction

  assign wr_ok = enable && idle && div_wr;
  assign tick  = !idle && (cnt_q == div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (wr_ok) begin
      div_q <= div_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (idle) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= next_phase(cnt_q, div_q);
    end
  end

endmodule

// File: rtl/rng_decim.sv
module rng_decim #(
  parameter int DEC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [DEC_W-1:0] dec_code,
  output logic             keep
);

  logic [DEC_W-1:0] grp_q;

  function automatic logic group_last(input logic [DEC_W-1:0] c,
                                      input logic [DEC_W-1:0] d);
    return c == d;
  endfunction

  assign keep = step && group_last(grp_q, dec_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= '0;
    end else if (clr) begin
      grp_q <= '0;
    end else if (step) begin
      grp_q <= group_last(grp_q, dec_code) ? '0 : grp_q + DEC_W'(1);
    end
  end

endmodule

// File: rtl/rng_shift.sv
module rng_shift #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              keep,
  input  logic              bit_in,
  input  logic              rd_stb,
  output logic [WORD_W-1:0] word_q,
  output logic              rdy_q,
  output logic              word_done
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] bits_q;

  function automatic logic [WORD_W-1:0] shift_in(input logic [WORD_W-1:0] w,
                                                 input logic b);
    return {w[WORD_W-2:0], b};
  endfunction

  assign word_done = keep && (bits_q == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      bits_q <= '0;
      rdy_q  <= 1'b0;
    end else if (clr) begin
      word_q <= '0;
      bits_q <= '0;
      rdy_q  <= 1'b0;
    end else if (rdy_q) begin
      if (rd_stb) begin
        rdy_q <= 1'b0;
      end
    end else if (keep) begin
      word_q <= shift_in(word_q, bit_in);
      if (word_done) begin
        bits_q <= '0;
        rdy_q  <= 1'b1;
      end else begin
        bits_q <= bits_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/rng_capture.sv
module rng_capture
  import rng_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 8,
  parameter int DEC_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              run_req,
  input  logic              div_wr,
  input  logic [DIV_W-1:0]  div_wdata,
  input  logic [DEC_W-1:0]  dec_code,
  input  logic              noise_in,
  input  logic              rd_stb,
  output logic [WORD_W-1:0] cap_word,
  output logic              rdy_irq,
  output logic [DIV_W-1:0]  div_value
);

  rng_state_e state_q;
  logic       idle;
  logic       tick;
  logic       step;
  logic       keep;
  logic       word_done;

  assign idle = (state_q == ST_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
    end else begin
      state_q <= (enable && run_req) ? ST_CAPTURE : ST_OFF;
    end
  end

  rng_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .idle     (idle),
    .div_wr   (div_wr),
    .div_wdata(div_wdata),
    .div_q    (div_value),
    .tick     (tick)
  );

  assign step = tick && !rdy_irq;

  rng_decim #(.DEC_W(DEC_W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (idle),
    .step    (step),
    .dec_code(dec_code),
    .keep    (keep)
  );

  rng_shift #(.WORD_W(WORD_W)) u_shf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (idle),
    .keep     (keep),
    .bit_in   (noise_in),
    .rd_stb   (rd_stb),
    .word_q   (cap_word),
    .rdy_q    (rdy_irq),
    .word_done(word_done)
  );

endmodule

module rng_capture_chk #(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              idle,
  input logic              div_wr,
  input logic [DIV_W-1:0]  div_value,
  input logic              tick,
  input logic              keep,
  input logic              rd_stb,
  input logic              rdy_irq,
  input logic [WORD_W-1:0] cap_word
);

  assert_no_tick_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !tick);

  assert_keep_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    keep |-> tick);

  assert_ready_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_irq && !rd_stb && !idle) |=> (rdy_irq && $stable(cap_word)));

  assert_ready_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_irq) |-> $past(keep));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_irq && rd_stb) |=> !rdy_irq);

  assert_div_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(enable && idle && div_wr) |=> $stable(div_value));

  assert_idle_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (cap_word == '0 && !rdy_irq));

endmodule

bind rng_capture rng_capture_chk #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .idle     (idle),
  .div_wr   (div_wr),
  .div_value(div_value),
  .tick     (tick),
  .keep     (keep),
  .rd_stb   (rd_stb),
  .rdy_irq  (rdy_irq),
  .cap_word (cap_word)
);

// File: tb/sim_rng_capture.sv
module sim_rng_capture;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        run_req = 1'b0;
  logic        div_wr = 1'b0;
  logic [7:0]  div_wdata = '0;
  logic [1:0]  dec_code = '0;
  logic        noise_in = 1'b0;
  logic        rd_stb = 1'b0;
  logic [31:0] cap_word;
  logic        rdy_irq;
  logic [7:0]  div_value;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rng_capture u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .run_req(run_req),
    .div_wr(div_wr), .div_wdata(div_wdata), .dec_code(dec_code),
    .noise_in(noise_in), .rd_stb(rd_stb), .cap_word(cap_word),
    .rdy_irq(rdy_irq), .div_value(div_value)
  );

  function automatic int word_len(input int r, input int d);
    return 32 * (r + 1) * (d + 1);
  endfunction

  function automatic bit kept_cycle(input int k, input int r, input int d);
    return ((k + 1) % ((r + 1) * (d + 1))) == 0;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic set_div(input int v);
    @(negedge clk);
    div_wr = 1'b1;
    div_wdata = 8'(v);
    @(negedge clk);
    div_wr = 1'b0;
  endtask

  task automatic go_idle();
    @(negedge clk);
    run_req = 1'b0;
    @(posedge clk);
    @(posedge clk);
  endtask

  // Caller has just passed the edge that starts collection (cycle 0 follows).
  // mode 0: random bits; mode 1: only the first kept bit is 1.
  task automatic collect(input int r, input int d, input int mode, input int stray_at,
                         input string req);
    logic [31:0] exp = '0;
    int len = word_len(r, d);
    int kept = 0;
    for (int k = 0; k <= len; k++) begin
      @(negedge clk);
      rd_stb = (k == stray_at);
      if (k == len - 1) check(rdy_irq == 1'b0, req, rdy_irq, 0);
      if (k == len) begin
        check(rdy_irq == 1'b1, req, rdy_irq, 1);
        check(cap_word == exp, req, cap_word, exp);
        break;
      end
      noise_in = (mode == 1) ? (kept == 0) : 1'($urandom);
      if (kept_cycle(k, r, d)) begin
        exp = {exp[30:0], noise_in};
        kept++;
      end
      @(posedge clk);
    end
    rd_stb = 1'b0;
  endtask

  task automatic start_word(input int r, input int d, input int mode, input int stray_at,
                            input string req);
    @(negedge clk);
    dec_code = 2'(d);
    run_req = 1'b1;
    @(posedge clk);
    collect(r, d, mode, stray_at, req);
  endtask

  task automatic hold_and_read(input bit restart);
    logic [31:0] snap = cap_word;
    bit held = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      noise_in = 1'($urandom);
      if (!rdy_irq || cap_word != snap) held = 1'b0;
    end
    check(held, "R6 hold", held, 1);
    @(negedge clk);
    rd_stb = 1'b1;
    @(posedge clk);
    if (restart) begin
      collect(0, 0, 0, -1, "R7 restart");
    end else begin
      @(negedge clk);
      rd_stb = 1'b0;
      check(rdy_irq == 1'b0, "R7 clear", rdy_irq, 0);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cap_word == '0, "R10 word", cap_word, 0);
    check(rdy_irq == 1'b0, "R10 irq", rdy_irq, 0);
    check(div_value == '0, "R10 div", div_value, 0);

    // R8: disabled write ignored, enabled idle write taken
    set_div(5);
    check(div_value == 8'd0, "R8 disabled write", div_value, 0);
    enable = 1'b1;
    set_div(0);
    check(div_value == 8'd0, "R8 idle write", div_value, 0);

    // R1 and R5: single leading one lands in bit 31
    start_word(0, 0, 1, -1, "R1 R5 dec0");
    check(cap_word == 32'h8000_0000, "R5 msb first", cap_word, 32'h8000_0000);
    hold_and_read(1'b1);
    hold_and_read(1'b0);

    // R9: drop run_req mid-word
    go_idle();
    start_word(0, 0, 0, -1, "R1 second");
    go_idle();
    @(negedge clk);
    check(cap_word == '0 && rdy_irq == 1'b0, "R9 run drop", cap_word, 0);

    // R2: decimate by four
    start_word(0, 3, 0, -1, "R2 dec3");
    // R8: write while capturing ignored
    set_div(6);
    check(div_value == 8'd0, "R8 capture write", div_value, 0);
    // R9: dropping enable clears ready
    @(negedge clk);
    enable = 1'b0;
    run_req = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check(cap_word == '0 && rdy_irq == 1'b0, "R9 enable drop", rdy_irq, 0);
    enable = 1'b1;

    // R3 R4 R11: random divider and decimation, stray read during collection
    for (int t = 0; t < 8; t++) begin
      int r = int'($urandom % 4);
      int d = int'($urandom % 4);
      int s = 1 + int'($urandom % 20);
      set_div(r);
      check(div_value == 8'(r), "R8 program", div_value, r);
      start_word(r, d, 0, s, "R3 R4 R11 random");
      hold_and_read(1'b0);
      go_idle();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule